// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight binary lock flags that a left and a right agent share. Each side has its own select, write strobe, output enable, 3-bit flag index and single write bit. Writing 0 asks for a flag's token and writing 1 gives it back. A read returns the flag as that side sees it, spread across a whole byte. The flags only mark ownership. Software decides what each flag protects, and the block enforces no lockout on anything else.

Each flag keeps one request latch per side and an owner state. A request that arrives while the other side holds the token stays latched. It takes the token by itself when the holder releases. When both sides ask for a free flag on the same clock edge, exactly one of them wins. The winner alternates between ties on that flag, and the left side wins the first tie after reset. A read value is captured on the first edge of a read and stays frozen until the read ends.

Reset clears only the read registers and the tie pointers. The flag state itself is not reset, so software must write 1 to every flag from both sides before use.

Top module: `sem_bank`

## Requirements
- R1: When a flag has no owner and no pending request, a 0 written by one side makes that side the owner. From the next edge that side reads 8'h00 and the other side reads 8'hFF.
- R2: A 0 written by the side that does not own a flag leaves both read values unchanged and sets that side's pending request.
- R3: When the owner writes 1 while the other side has a request pending, the token passes to the pending side. The read values of the two sides swap.
- R4: When the owner writes 1 and no request is pending, the flag becomes free and reads 8'hFF on both sides.
- R5: A side that writes 1 while its request is pending withdraws the request. A later release by the owner then frees the flag.
- R6: A read returns the flag value on all data bits. The byte is 8'h00 when that side holds the token and 8'hFF otherwise.
- R7: A read is active while sel=1, oe=1 and wr=0. The value is captured on the first clock edge of an active read and does not change while the read stays active, even when the token moves. A new read is needed to see the change.
- R8: When both sides write 0 to the same free flag on the same edge, exactly one side becomes the owner and the other side's request stays pending. The left side wins the first tie after reset, and later ties on that flag alternate sides.
- R9: A request made on the edge before the other side's request wins the token.
- R10: A 1 written by the non-owning side, with no request of its own pending, has no effect on the flag.
- R11: Flags are independent. A write addressed to one index does not change what any other index reads.
- R12: After reset both read registers hold 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read registers and tie pointers |
| l_sel | input | 1 | Left side select |
| l_wr | input | 1 | Left write strobe; with l_sel=1, one write per clock edge |
| l_oe | input | 1 | Left output enable |
| l_idx | input | 3 | Left flag index |
| l_wbit | input | 1 | Left write data bit (0 request, 1 release) |
| l_rdata | output | 8 | Left captured read byte |
| r_sel | input | 1 | Right side select |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_idx | input | 3 | Right flag index |
| r_wbit | input | 1 | Right write data bit |
| r_rdata | output | 8 | Right captured read byte |

## Verification
A write takes effect on the edge where it is presented. The earliest read that can observe it starts on the next edge, and its byte is valid just after that edge. The bench drives all inputs on falling edges and holds each write for one cycle. It samples read bytes on the falling edge after the capture edge, and it leaves one idle cycle between reads so that each read starts fresh. For the frozen-read case, the bench keeps the read active while the other side hands over the token. It samples the held byte again after that handover, then starts a new read to see the new value.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } own_e;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic wbit_l,
  input  logic wr_r,
  input  logic wbit_r,
  output logic hold_l,
  output logic hold_r,
  output logic pend_l,
  output logic pend_r
);
  // request latches and owner carry no reset: software initialises them
  logic req_l, req_r, req_l_n, req_r_n;
  own_e own_q, own_n;
  logic favor_r, favor_r_n;  // 0: left wins next tie

  assign req_l_n = wr_l ? ~wbit_l : req_l;
  assign req_r_n = wr_r ? ~wbit_r : req_r;

  always_comb begin
    own_n     = own_q;
    favor_r_n = favor_r;
    case (own_q)
      OWN_LEFT: begin
        if (!req_l_n) own_n = req_r_n ? OWN_RIGHT : OWN_NONE;
      end
      OWN_RIGHT: begin
        if (!req_r_n) own_n = req_l_n ? OWN_LEFT : OWN_NONE;
      end
      default: begin
        if (req_l_n && req_r_n) begin
          own_n     = favor_r ? OWN_RIGHT : OWN_LEFT;
          favor_r_n = ~favor_r;
        end else if (req_l_n) begin
          own_n = OWN_LEFT;
        end else if (req_r_n) begin
          own_n = OWN_RIGHT;
        end else begin
          own_n = OWN_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    req_l <= req_l_n;
    req_r <= req_r_n;
    own_q <= own_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) favor_r <= 1'b0;
    else        favor_r <= favor_r_n;
  end

  assign hold_l = (own_q == OWN_LEFT);
  assign hold_r = (own_q == OWN_RIGHT);
  assign pend_l = req_l & ~hold_l;
  assign pend_r = req_r & ~hold_r;
endmodule

// File: rtl/sem_wr_dec.sv
module sem_wr_dec #(
  parameter int N_FLAGS = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input  logic             sel,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  output logic [N_FLAGS-1:0] strobe
);
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_dec
    assign strobe[g] = sel & wr & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
  parameter int N_FLAGS = 8,
  parameter int RD_W    = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               oe,
  input  logic               wr,
  input  logic [IDX_W-1:0]   idx,
  input  logic [N_FLAGS-1:0] view,
  output logic [RD_W-1:0]    rdata
);
  logic rd, rd_q;
  assign rd = sel & oe & ~wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      rdata <= '1;
    end else begin
      rd_q <= rd;
      if (rd && !rd_q) rdata <= {RD_W{view[idx]}};
    end
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int N_FLAGS = 8,
  parameter int RD_W    = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l_sel,
  input  logic             l_wr,
  input  logic             l_oe,
  input  logic [IDX_W-1:0] l_idx,
  input  logic             l_wbit,
  output logic [RD_W-1:0]  l_rdata,
  input  logic             r_sel,
  input  logic             r_wr,
  input  logic             r_oe,
  input  logic [IDX_W-1:0] r_idx,
  input  logic             r_wbit,
  output logic [RD_W-1:0]  r_rdata
);
  logic [N_FLAGS-1:0] stb_l, stb_r;
  logic [N_FLAGS-1:0] hold_l_v, hold_r_v, pend_l_v, pend_r_v;

  sem_wr_dec #(.N_FLAGS(N_FLAGS)) u_dec_l (
    .sel(l_sel), .wr(l_wr), .idx(l_idx), .strobe(stb_l));
  sem_wr_dec #(.N_FLAGS(N_FLAGS)) u_dec_r (
    .sel(r_sel), .wr(r_wr), .idx(r_idx), .strobe(stb_r));

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_l(stb_l[g]), .wbit_l(l_wbit),
      .wr_r(stb_r[g]), .wbit_r(r_wbit),
      .hold_l(hold_l_v[g]), .hold_r(hold_r_v[g]),
      .pend_l(pend_l_v[g]), .pend_r(pend_r_v[g]));
  end

  sem_rd_port #(.N_FLAGS(N_FLAGS), .RD_W(RD_W)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .sel(l_sel), .oe(l_oe), .wr(l_wr),
    .idx(l_idx), .view(~hold_l_v), .rdata(l_rdata));
  sem_rd_port #(.N_FLAGS(N_FLAGS), .RD_W(RD_W)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .sel(r_sel), .oe(r_oe), .wr(r_wr),
    .idx(r_idx), .view(~hold_r_v), .rdata(r_rdata));
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int N_FLAGS = 8,
  parameter int RD_W    = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_sel,
  input logic               l_wr,
  input logic               l_oe,
  input logic [IDX_W-1:0]   l_idx,
  input logic               l_wbit,
  input logic [RD_W-1:0]    l_rdata,
  input logic               r_sel,
  input logic               r_wr,
  input logic               r_oe,
  input logic [IDX_W-1:0]   r_idx,
  input logic               r_wbit,
  input logic [RD_W-1:0]    r_rdata,
  input logic [N_FLAGS-1:0] hold_l,
  input logic [N_FLAGS-1:0] hold_r,
  input logic [N_FLAGS-1:0] pend_l,
  input logic [N_FLAGS-1:0] pend_r
);
  logic l_rd, r_rd, l_w0, l_w1, r_w0, r_touch;
  assign l_rd    = l_sel & l_oe & ~l_wr;
  assign r_rd    = r_sel & r_oe & ~r_wr;
  assign l_w0    = l_sel & l_wr & ~l_wbit;
  assign l_w1    = l_sel & l_wr & l_wbit;
  assign r_w0    = r_sel & r_wr & ~r_wbit;
  assign r_touch = r_sel & r_wr & (r_idx == l_idx);

  // R6
  byte_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  // R7
  l_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && l_rd && $past(l_rd) |-> $stable(l_rdata));

  // R7
  r_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && r_rd && $past(r_rd) |-> $stable(r_rdata));

  // R1
  take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_w0 && !r_touch && !hold_l[l_idx] && !hold_r[l_idx] && !pend_r[l_idx]
    |=> hold_l[$past(l_idx)]);

  // R2
  loser_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_w0 && !r_touch && hold_r[l_idx]
    |=> hold_r[$past(l_idx)] && pend_l[$past(l_idx)]);

  // R3
  hand_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_w1 && !r_touch && hold_l[l_idx] && pend_r[l_idx]
    |=> hold_r[$past(l_idx)]);

  // R4
  release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_w1 && !r_touch && hold_l[l_idx] && !pend_r[l_idx]
    |=> !hold_l[$past(l_idx)] && !hold_r[$past(l_idx)]);

  // R8
  tie_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_w0 && r_w0 && (r_idx == l_idx) && !hold_l[l_idx] && !hold_r[l_idx]
    && !pend_l[l_idx] && !pend_r[l_idx]
    |=> $countones({hold_l[$past(l_idx)], hold_r[$past(l_idx)]}) == 1);
endmodule

bind sem_bank sem_bank_chk #(.N_FLAGS(N_FLAGS), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_idx(l_idx), .l_wbit(l_wbit),
  .l_rdata(l_rdata),
  .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_idx(r_idx), .r_wbit(r_wbit),
  .r_rdata(r_rdata),
  .hold_l(hold_l_v), .hold_r(hold_r_v), .pend_l(pend_l_v), .pend_r(pend_r_v));

// File: tb/sem_bank_test.sv
module sem_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_wr = 0, l_oe = 0, l_wbit = 0;
  logic r_sel = 0, r_wr = 0, r_oe = 0, r_wbit = 0;
  logic [2:0] l_idx = 0, r_idx = 0;
  logic [7:0] l_rdata, r_rdata;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sem_bank uut (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_idx(l_idx), .l_wbit(l_wbit),
    .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_idx(r_idx), .r_wbit(r_wbit),
    .r_rdata(r_rdata));

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit right, input int idx, input bit d);
    @(negedge clk);
    if (right) begin r_sel = 1; r_wr = 1; r_idx = 3'(idx); r_wbit = d; end
    else       begin l_sel = 1; l_wr = 1; l_idx = 3'(idx); l_wbit = d; end
    @(negedge clk);
    l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
  endtask

  task automatic wr_both(input int idx, input bit dl, input bit dr);
    @(negedge clk);
    l_sel = 1; l_wr = 1; l_idx = 3'(idx); l_wbit = dl;
    r_sel = 1; r_wr = 1; r_idx = 3'(idx); r_wbit = dr;
    @(negedge clk);
    l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
  endtask

  task automatic rd_pair(input string req, input int idx,
                         input logic [7:0] el, input logic [7:0] er);
    @(negedge clk);
    l_sel = 1; l_oe = 1; l_idx = 3'(idx);
    r_sel = 1; r_oe = 1; r_idx = 3'(idx);
    @(negedge clk);
    chk(req, $sformatf("left read flag %0d", idx), l_rdata, el);
    chk(req, $sformatf("right read flag %0d", idx), r_rdata, er);
    l_sel = 0; l_oe = 0; r_sel = 0; r_oe = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12", "left after reset", l_rdata, 8'hFF);
    chk("R12", "right after reset", r_rdata, 8'hFF);
  endtask

  task automatic t_init;
    for (int i = 0; i < 8; i++) wr_both(i, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) rd_pair("R4", i, 8'hFF, 8'hFF);
  endtask

  task automatic t_procure;
    wr(0, 0, 0); rd_pair("R1", 0, 8'h00, 8'hFF);
    wr(1, 0, 0); rd_pair("R2", 0, 8'h00, 8'hFF);
    wr(0, 0, 1); rd_pair("R3", 0, 8'hFF, 8'h00);
    wr(0, 0, 0); rd_pair("R2", 0, 8'hFF, 8'h00);
    wr(1, 0, 1); rd_pair("R3", 0, 8'h00, 8'hFF);
    wr(0, 0, 1); rd_pair("R4", 0, 8'hFF, 8'hFF);
    wr(1, 0, 0); rd_pair("R1", 0, 8'hFF, 8'h00);
    wr(1, 0, 1); rd_pair("R4", 0, 8'hFF, 8'hFF);
    wr(0, 0, 0); rd_pair("R1", 0, 8'h00, 8'hFF);
    wr(0, 0, 1); rd_pair("R4", 0, 8'hFF, 8'hFF);
  endtask

  task automatic t_nonowner_release;
    wr(0, 2, 0);
    wr(1, 2, 1); rd_pair("R10", 2, 8'h00, 8'hFF);
    wr(0, 2, 1); rd_pair("R10", 2, 8'hFF, 8'hFF);
  endtask

  task automatic t_withdraw;
    wr(0, 3, 0);
    wr(1, 3, 0);
    wr(1, 3, 1); rd_pair("R5", 3, 8'h00, 8'hFF);
    wr(0, 3, 1); rd_pair("R5", 3, 8'hFF, 8'hFF);
  endtask

  task automatic t_independent;
    wr(0, 4, 0);
    rd_pair("R11", 5, 8'hFF, 8'hFF);
    rd_pair("R11", 3, 8'hFF, 8'hFF);
    rd_pair("R11", 4, 8'h00, 8'hFF);
    wr(0, 4, 1); rd_pair("R11", 4, 8'hFF, 8'hFF);
  endtask

  task automatic t_tie;
    wr_both(6, 0, 0); rd_pair("R8", 6, 8'h00, 8'hFF);   // first tie: left
    wr(0, 6, 1);      rd_pair("R8", 6, 8'hFF, 8'h00);   // loser was pending
    wr(1, 6, 1);      rd_pair("R4", 6, 8'hFF, 8'hFF);
    wr_both(6, 0, 0); rd_pair("R8", 6, 8'hFF, 8'h00);   // second tie: right
    wr(1, 6, 1);      rd_pair("R3", 6, 8'h00, 8'hFF);
    wr(0, 6, 1);
    wr_both(6, 0, 0); rd_pair("R8", 6, 8'h00, 8'hFF);   // third tie: left
    wr_both(6, 1, 1); rd_pair("R4", 6, 8'hFF, 8'hFF);
  endtask

  task automatic t_earlier;
    @(negedge clk);
    l_sel = 1; l_wr = 1; l_idx = 3'd7; l_wbit = 0;
    @(negedge clk);
    l_sel = 0; l_wr = 0;
    r_sel = 1; r_wr = 1; r_idx = 3'd7; r_wbit = 0;
    @(negedge clk);
    r_sel = 0; r_wr = 0;
    rd_pair("R9", 7, 8'h00, 8'hFF);
    wr(1, 7, 1); wr(0, 7, 1); rd_pair("R9", 7, 8'hFF, 8'hFF);
  endtask

  task automatic t_frozen;
    wr(0, 1, 0);
    wr(1, 1, 0);
    @(negedge clk);
    r_sel = 1; r_oe = 1; r_idx = 3'd1;
    @(negedge clk);
    chk("R7", "held read before handover", r_rdata, 8'hFF);
    l_sel = 1; l_wr = 1; l_idx = 3'd1; l_wbit = 1;
    @(negedge clk);
    l_sel = 0; l_wr = 0;
    @(negedge clk);
    chk("R7", "held read after handover", r_rdata, 8'hFF);
    r_sel = 0; r_oe = 0;
    @(negedge clk);
    rd_pair("R7", 1, 8'hFF, 8'h00);
    wr(1, 1, 1); rd_pair("R4", 1, 8'hFF, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_init();
    t_procure();
    t_nonowner_release();
    t_withdraw();
    t_independent();
    t_tie();
    t_earlier();
    t_frozen();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule